// File: doc/BRIEF.md
# Serial Receiver Status Flag Register

This block keeps the status flags of an asynchronous serial transceiver and sits beside its receive and transmit datapaths. It does not shift or time any bits. The receiver sends it a pulse for each completed character, together with that character and the results of the stop-bit and parity checks. The transmitter sends pulses when the CPU loads the holding register, when the holding register moves into the shifter, and when the shifter runs dry. From these events the block keeps ready, empty and error flags. It also holds the most recently received character for the CPU.

The CPU sees one status byte. A read strobe on the data register consumes the held character. A command write carries an error-reset bit, and that bit is the only way to clear the sticky error flags. No error ever stops reception. An overrun drops the unread character, keeps the newer one and raises a flag. Sync detect and the modem data-set-ready input are passed straight through into the byte.

Top module: `sr_status_reg`

## Requirements
- R1: While reset is asserted and right after it, status_o reads 0x05 (only transmitter-ready at bit 0 and transmitter-empty at bit 2 set, with sync_det_i and dsr_i low), and rx_data_o reads 0.
- R2: A cycle with rx_done_i high sets receiver-ready (status bit 1) and loads rx_char_i into rx_data_o at that clock edge.
- R3: A cycle with cpu_rd_data_i high clears receiver-ready at that edge, unless rx_done_i is also high in the same cycle, in which case receiver-ready stays set.
- R4: If rx_done_i arrives while receiver-ready is set and no read happens in that cycle, the overrun flag (status bit 4) is set and rx_data_o takes the newer character.
- R5: rx_done_i with rx_par_bad_i sets the parity flag (bit 3), and rx_done_i with rx_stop_bad_i sets the framing flag (bit 5). The check inputs have no effect without rx_done_i.
- R6: The error flags are sticky. While any of them is set, later characters are still accepted and update receiver-ready and rx_data_o as usual.
- R7: A cycle with cmd_wr_i high and cmd_i bit 4 equal to 1 clears all three error flags. A command with bit 4 equal to 0 leaves them unchanged. An error raised in the same cycle as the clear wins and stays set.
- R8: Transmitter-ready (bit 0) is cleared by tx_hold_load_i and set by tx_hold_xfer_i. If both are high in one cycle, the load wins.
- R9: Transmitter-empty (bit 2) is cleared by tx_hold_xfer_i and set by tx_shift_idle_i. If both are high in one cycle, the transfer wins.
- R10: Status bit 6 follows sync_det_i and bit 7 follows dsr_i in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_done_i | input | 1 | Receiver completed a character this cycle |
| rx_char_i | input | DATA_W | Completed character |
| rx_stop_bad_i | input | 1 | Stop-bit check failed for this character |
| rx_par_bad_i | input | 1 | Parity check failed for this character |
| cpu_rd_data_i | input | 1 | CPU reads the receive data register |
| cmd_wr_i | input | 1 | CPU writes a command byte |
| cmd_i | input | 8 | Command byte; bit 4 requests error reset |
| tx_hold_load_i | input | 1 | CPU loaded the transmit holding register |
| tx_hold_xfer_i | input | 1 | Holding register moved into the shifter |
| tx_shift_idle_i | input | 1 | Shifter finished with nothing queued |
| sync_det_i | input | 1 | Sync-detect level from the hunt logic |
| dsr_i | input | 1 | Modem data-set-ready pin |
| status_o | output | 8 | Status byte {dsr, sync, FE, OE, PE, TxEMPTY, RxRDY, TxRDY} |
| rx_data_o | output | DATA_W | Most recent received character |

## Verification
Random traffic mixes character arrivals, reads, commands and transmit events at rates that make collisions common. This reaches the cases where a read and an arrival share a cycle, which tells a proper overrun apart from one that is only apparent. It also reaches cases where an error and an error-reset share a cycle, which shows whether set or clear takes priority. Directed sequences cover cases that random traffic reaches only by chance. A double arrival with no read in between shows that the newer byte is kept. A command without the reset bit shows that the flags stay sticky. A load and a transfer in the same cycle fixes the transmit priorities. A reset applied in the middle of a run checks the values that reset leaves.

// File: rtl/sr_status_pkg.sv
package sr_status_pkg;
  localparam int ST_W       = 8;
  localparam int ST_TXRDY   = 0;
  localparam int ST_RXRDY   = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_PE      = 3;
  localparam int ST_OE      = 4;
  localparam int ST_FE      = 5;
  localparam int ST_SYNC    = 6;
  localparam int ST_DSR     = 7;
  // sticky error flags occupy contiguous status bits starting at ST_PE
  localparam int N_ERR      = 3;
  localparam int ERR_PAR    = 0;
  localparam int ERR_OVR    = 1;
  localparam int ERR_FRM    = 2;
endpackage

// File: rtl/sr_rst_sync.sv
module sr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/sr_sticky_flag.sv
module sr_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  // set has priority so an error raised during a clear is not lost
  always_comb begin
    flag_d = set_i | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/sr_rx_flags.sv
module sr_rx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_char_i,
  input  logic              rd_strobe_i,
  output logic              rxrdy_o,
  output logic              overrun_o,
  output logic [DATA_W-1:0] data_o
);
  logic              rxrdy_q, rxrdy_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;

  always_comb begin
    rxrdy_d   = rx_done_i | (rxrdy_q & ~rd_strobe_i);
    overrun_o = rx_done_i & rxrdy_q & ~rd_strobe_i;
    data_en   = rx_done_i;
    data_d    = data_en ? rx_char_i : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxrdy_q <= 1'b0;
      data_q  <= '0;
    end else begin
      rxrdy_q <= rxrdy_d;
      data_q  <= data_d;
    end
  end

  assign rxrdy_o = rxrdy_q;
  assign data_o  = data_q;
endmodule

// File: rtl/sr_tx_flags.sv
module sr_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_load_i,
  input  logic hold_xfer_i,
  input  logic shift_idle_i,
  output logic txrdy_o,
  output logic txempty_o
);
  logic txrdy_q, txrdy_d;
  logic empty_q, empty_d;

  always_comb begin
    txrdy_d = txrdy_q;
    if (hold_load_i)      txrdy_d = 1'b0;
    else if (hold_xfer_i) txrdy_d = 1'b1;

    empty_d = empty_q;
    if (hold_xfer_i)       empty_d = 1'b0;
    else if (shift_idle_i) empty_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txrdy_q <= 1'b1;
      empty_q <= 1'b1;
    end else begin
      txrdy_q <= txrdy_d;
      empty_q <= empty_d;
    end
  end

  assign txrdy_o   = txrdy_q;
  assign txempty_o = empty_q;
endmodule

// File: rtl/sr_status_reg.sv
module sr_status_reg
  import sr_status_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int ERR_RST_BIT = 4,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_char_i,
  input  logic              rx_stop_bad_i,
  input  logic              rx_par_bad_i,
  input  logic              cpu_rd_data_i,
  input  logic              cmd_wr_i,
  input  logic [7:0]        cmd_i,
  input  logic              tx_hold_load_i,
  input  logic              tx_hold_xfer_i,
  input  logic              tx_shift_idle_i,
  input  logic              sync_det_i,
  input  logic              dsr_i,
  output logic [ST_W-1:0]   status_o,
  output logic [DATA_W-1:0] rx_data_o
);
  logic             rst_n_sync;
  logic             rxrdy, overrun_evt;
  logic             txrdy, txempty;
  logic [N_ERR-1:0] err_set;
  logic [N_ERR-1:0] err_q;
  logic             err_clr;
  logic [7:0]       cmd_unused;

  assign cmd_unused = cmd_i;

  sr_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_sync)
  );

  sr_rx_flags #(.DATA_W(DATA_W)) u_rx (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .rx_done_i   (rx_done_i),
    .rx_char_i   (rx_char_i),
    .rd_strobe_i (cpu_rd_data_i),
    .rxrdy_o     (rxrdy),
    .overrun_o   (overrun_evt),
    .data_o      (rx_data_o)
  );

  sr_tx_flags u_tx (
    .clk          (clk),
    .rst_n        (rst_n_sync),
    .hold_load_i  (tx_hold_load_i),
    .hold_xfer_i  (tx_hold_xfer_i),
    .shift_idle_i (tx_shift_idle_i),
    .txrdy_o      (txrdy),
    .txempty_o    (txempty)
  );

  always_comb begin
    err_set          = '0;
    err_set[ERR_PAR] = rx_done_i & rx_par_bad_i;
    err_set[ERR_OVR] = overrun_evt;
    err_set[ERR_FRM] = rx_done_i & rx_stop_bad_i;
    err_clr          = cmd_wr_i & cmd_i[ERR_RST_BIT];
  end

  for (genvar gi = 0; gi < N_ERR; gi++) begin : g_err
    sr_sticky_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n_sync),
      .set_i  (err_set[gi]),
      .clr_i  (err_clr),
      .flag_o (err_q[gi])
    );
  end

  always_comb begin
    status_o                    = '0;
    status_o[ST_TXRDY]          = txrdy;
    status_o[ST_RXRDY]          = rxrdy;
    status_o[ST_TXEMPTY]        = txempty;
    status_o[ST_PE +: N_ERR]    = err_q;
    status_o[ST_SYNC]           = sync_det_i;
    status_o[ST_DSR]            = dsr_i;
  end
endmodule

// File: rtl/sr_status_chk.sv
module sr_status_chk
  import sr_status_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_done_i,
  input logic [DATA_W-1:0] rx_char_i,
  input logic              cpu_rd_data_i,
  input logic              cmd_wr_i,
  input logic              cmd_er_i,
  input logic              tx_hold_load_i,
  input logic              tx_hold_xfer_i,
  input logic [ST_W-1:0]   status_o,
  input logic [DATA_W-1:0] rx_data_o
);
  AST_RXRDY_ON_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_i |=> status_o[ST_RXRDY]); // R2
  AST_RXRDY_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_data_i && !rx_done_i |=> !status_o[ST_RXRDY]); // R3
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_i && status_o[ST_RXRDY] && !cpu_rd_data_i |=> status_o[ST_OE]); // R4
  AST_DATA_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done_i |=> rx_data_o == $past(rx_char_i)); // R4
  AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[ST_FE] && !(cmd_wr_i && cmd_er_i) |=> status_o[ST_FE]); // R6
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_i && cmd_er_i && !rx_done_i |=>
      !status_o[ST_PE] && !status_o[ST_OE] && !status_o[ST_FE]); // R7
  AST_TXRDY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hold_load_i |=> !status_o[ST_TXRDY]); // R8
  AST_TXEMPTY_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    tx_hold_xfer_i |=> !status_o[ST_TXEMPTY]); // R9
endmodule

bind sr_status_reg sr_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n_sync),
  .rx_done_i      (rx_done_i),
  .rx_char_i      (rx_char_i),
  .cpu_rd_data_i  (cpu_rd_data_i),
  .cmd_wr_i       (cmd_wr_i),
  .cmd_er_i       (cmd_i[ERR_RST_BIT]),
  .tx_hold_load_i (tx_hold_load_i),
  .tx_hold_xfer_i (tx_hold_xfer_i),
  .status_o       (status_o),
  .rx_data_o      (rx_data_o)
);

// File: tb/test_sr_status_reg.sv
module test_sr_status_reg;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rx_done, stop_bad, par_bad, rd, cmd_wr;
  logic [DW-1:0] rx_char;
  logic [7:0]    cmd;
  logic          hload, hxfer, sidle, syncd, dsr;
  logic [7:0]    status;
  logic [DW-1:0] rx_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench reference state
  logic m_txrdy, m_rxrdy, m_empty, m_pe, m_oe, m_fe;
  logic [DW-1:0] m_data;

  always #10 clk = ~clk;

  sr_status_reg i_sr_status_reg (
    .clk(clk), .rst_n(rst_n), .rx_done_i(rx_done), .rx_char_i(rx_char),
    .rx_stop_bad_i(stop_bad), .rx_par_bad_i(par_bad), .cpu_rd_data_i(rd),
    .cmd_wr_i(cmd_wr), .cmd_i(cmd), .tx_hold_load_i(hload),
    .tx_hold_xfer_i(hxfer), .tx_shift_idle_i(sidle), .sync_det_i(syncd),
    .dsr_i(dsr), .status_o(status), .rx_data_o(rx_data)
  );

  function automatic logic [7:0] exp_status();
    return {dsr, syncd, m_fe, m_oe, m_pe, m_empty, m_rxrdy, m_txrdy};
  endfunction

  function automatic logic nxt_sticky(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_txrdy = 1'b1; m_empty = 1'b1; m_rxrdy = 1'b0;
    m_pe = 1'b0; m_oe = 1'b0; m_fe = 1'b0; m_data = '0;
  endtask

  task automatic model_step();
    logic ovr, clr;
    ovr = rx_done & m_rxrdy & ~rd;
    clr = cmd_wr & cmd[4];
    m_pe    = nxt_sticky(m_pe, rx_done & par_bad, clr);
    m_fe    = nxt_sticky(m_fe, rx_done & stop_bad, clr);
    m_oe    = nxt_sticky(m_oe, ovr, clr);
    m_rxrdy = rx_done | (m_rxrdy & ~rd);
    if (rx_done) m_data = rx_char;
    if (hload) m_txrdy = 1'b0; else if (hxfer) m_txrdy = 1'b1;
    if (hxfer) m_empty = 1'b0; else if (sidle) m_empty = 1'b1;
  endtask

  task automatic check_all();
    logic [7:0] e;
    e = exp_status();
    chk("R8 txrdy",   status[0], e[0]);
    chk("R2/R3 rxrdy", status[1], e[1]);
    chk("R9 txempty", status[2], e[2]);
    chk("R5/R7 pe",   status[3], e[3]);
    chk("R4/R6 oe",   status[4], e[4]);
    chk("R5/R7 fe",   status[5], e[5]);
    chk("R10 sync/dsr", status[7:6], e[7:6]);
    chk("R4/R6 data", rx_data, m_data);
  endtask

  task automatic idle_inputs();
    rx_done = 0; stop_bad = 0; par_bad = 0; rd = 0; cmd_wr = 0; cmd = '0;
    hload = 0; hxfer = 0; sidle = 0;
  endtask

  // inputs already driven (after a negedge); run one edge and compare
  task automatic step();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
    idle_inputs();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; idle_inputs(); rx_char = '0; syncd = 0; dsr = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 8'h05);
    chk("R1 reset data", rx_data, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", status, 8'h05);

    // R2: single character
    rx_done = 1; rx_char = 8'hA5; step();
    chk("R2 rxrdy set", status[1], 1'b1);
    chk("R2 data", rx_data, 8'hA5);
    // R4: second char without read -> overrun, newest kept
    rx_done = 1; rx_char = 8'h3C; step();
    chk("R4 overrun", status[4], 1'b1);
    chk("R4 newest data", rx_data, 8'h3C);
    // R3: read with simultaneous arrival keeps rxrdy, no new overrun needed
    rd = 1; rx_done = 1; rx_char = 8'h11; step();
    chk("R3 rxrdy kept", status[1], 1'b1);
    rd = 1; step();
    chk("R3 rxrdy cleared", status[1], 1'b0);
    // R5: check inputs without rx_done are ignored
    par_bad = 1; stop_bad = 1; cmd_wr = 1; cmd = 8'h10; step();
    chk("R5 ignored pe", status[3], 1'b0);
    chk("R5 ignored fe", status[5], 1'b0);
    // R5/R6: errors set, reception continues
    rx_done = 1; rx_char = 8'h77; par_bad = 1; stop_bad = 1; step();
    chk("R5 pe/fe set", {status[5], status[3]}, 2'b11);
    rd = 1; step();
    rx_done = 1; rx_char = 8'h42; step();
    chk("R6 accepts after error", rx_data, 8'h42);
    // R7: command without bit 4 keeps flags
    cmd_wr = 1; cmd = 8'hEF; step();
    chk("R7 no clear", {status[5], status[3]}, 2'b11);
    // R7: clear with simultaneous parity error -> set wins
    cmd_wr = 1; cmd = 8'h10; rx_done = 1; rd = 1; rx_char = 8'h09; par_bad = 1; step();
    chk("R7 set wins", {status[5], status[4], status[3]}, 3'b001);
    cmd_wr = 1; cmd = 8'h10; step();
    chk("R7 cleared", status[5:3], 3'b000);
    // R8/R9 priorities
    hload = 1; hxfer = 1; step();
    chk("R8 load wins", status[0], 1'b0);
    chk("R9 xfer clears empty", status[2], 1'b0);
    hxfer = 1; sidle = 1; step();
    chk("R9 xfer wins", status[2], 1'b0);
    sidle = 1; step();
    chk("R9 idle sets", status[2], 1'b1);
    // R10 passthrough
    syncd = 1; dsr = 0; #1 chk("R10 sync", status[7:6], 2'b01);
    dsr = 1; syncd = 0; #1 chk("R10 dsr", status[7:6], 2'b10);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      rx_done  = ($urandom % 100) < 30;
      rx_char  = DW'($urandom);
      par_bad  = ($urandom % 100) < 15;
      stop_bad = ($urandom % 100) < 15;
      rd       = ($urandom % 100) < 25;
      cmd_wr   = ($urandom % 100) < 10;
      cmd      = 8'($urandom);
      hload    = ($urandom % 100) < 20;
      hxfer    = ($urandom % 100) < 20;
      sidle    = ($urandom % 100) < 20;
      syncd    = 1'($urandom);
      dsr      = 1'($urandom);
      step();
    end

    // R1: asynchronous reset mid-run
    rx_done = 1; rx_char = 8'hFF; par_bad = 1; hload = 1; step();
    syncd = 0; dsr = 0;
    rst_n = 1'b0; #1;
    chk("R1 async reset status", status, 8'h05);
    chk("R1 async reset data", rx_data, 0);
    model_reset();
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule